// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits on the host side of a byte-wide parallel flash device. A client hands it one request at a time over a valid/ready handshake: write one byte at an address, wipe the whole device, or fetch the two identification bytes. The block expands each request into the series of bus writes the device expects, each prefixed by the two unlock writes. It then watches the device until the operation has finished.

Every bus cycle is timed by three parameters, counted in clocks: how long address and data settle, how long the strobe stays low, and how long everything is held after the strobe rises. Cycles of one request run back to back with chip-enable kept low. Completion of a program or erase is found by re-reading the operation's address and checking bit 7; no ready pin is used. A poll limit turns a device that never finishes into a timeout error, after which the device is sent a reset command. Each request ends with a one-clock done pulse that carries the result byte(s) and the error flags.

Top module: `flash_cmd_seq`

## Requirements
- R1: `req_ready` is 1 only while the block is idle; a request is taken on a clock where `req_valid` and `req_ready` are both 1, and a request offered while a request is in progress changes nothing on the flash pins or outputs.
- R2: With `req_op` = 0 (program), the block issues four writes: 555h/AAh, 2AAh/55h, 555h/A0h, then the request address with the request data.
- R3: With `req_op` = 1 (chip erase), the block issues six writes: 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, 555h/10h.
- R4: Every write holds chip-enable low, with address and data driven (`flash_dq_oe` = 1) and stable, for T_SETUP clocks with write-enable high, then T_PULSE clocks with write-enable low, then T_HOLD clocks with write-enable high. The next cycle follows at once, and write-enable and output-enable are never low together.
- R5: Every read keeps `flash_dq_oe` at 0 and has the same three-phase shape as a write. Output-enable is low during the strobe phase, and the data bus is sampled on the last clock of that phase.
- R6: After a program, the block reads the request address back to back until bit 7 of the read byte equals bit 7 of the written data. The last read byte is returned in `rsp_data[7:0]`, with `rsp_data[15:8]` = 0.
- R7: After a chip erase, the block reads the request address back to back until bit 7 reads 1. The last read byte is returned as in R6.
- R8: If MAX_POLLS reads in a row find the operation unfinished, polling stops. The block writes 555h/AAh, 2AAh/55h, 555h/F0h and then ends the request with `err_timeout` = 1.
- R9: With `req_op[1]` = 1 (identify), the block writes 555h/AAh, 2AAh/55h, 555h/90h. It then reads address 0 and address 1, then writes 555h/AAh, 2AAh/55h, 555h/F0h. It returns `rsp_data` = {byte at 1, byte at 0}.
- R10: On identify, `err_parity` is 1 when either identification byte holds an even number of ones, with bit 7 acting as the odd-parity bit.
- R11: `done` is high for exactly one clock, the clock after the last bus cycle ends. `rsp_data`, `err_timeout` and `err_parity` are 0 on every other clock, and `req_ready` returns on the clock after `done`.
- R12: After reset, chip-enable, write-enable and output-enable are high, `flash_dq_oe` is 0, `done` is 0 and `req_ready` is 1.
- R13: Program accepts any address, from 0 to all ones, with no boundary check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request will be taken |
| req_op | input | 2 | 0 program, 1 chip erase, 2 or 3 identify |
| req_addr | input | AW | Target address (program, erase poll) |
| req_data | input | 8 | Byte to program |
| done | output | 1 | One-clock completion pulse |
| rsp_data | output | 16 | Result bytes, valid with done |
| err_timeout | output | 1 | Poll limit reached, valid with done |
| err_parity | output | 1 | Identification parity mismatch, valid with done |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_addr | output | AW | Flash address |
| flash_dq_o | output | 8 | Data toward the device |
| flash_dq_oe | output | 1 | Data pad driver enable (0 means tri-stated) |
| flash_dq_i | input | 8 | Data from the device |

## Verification
The bench predicts every pin on every clock, so an off-by-one in any timing phase or a missing gap shows up at once as a shifted trace. It aims at the poll corner cases: a program that finishes on the first read, a device that finishes on the last read allowed, and one that never finishes. A sequencer that counted polls wrongly would issue one read too many or too few before the reset writes. One that compared the wrong bit would stop on the busy byte or never stop. Identify is run with good bytes and with an even-parity byte, and also with op code 3. A request held valid during a busy run must leave the trace untouched, which catches a sequencer that re-accepts mid-run.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    typedef enum logic [1:0] {
        OP_PROGRAM = 2'd0,
        OP_ERASE   = 2'd1,
        OP_IDENT   = 2'd2,
        OP_IDENT2  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        K_WRITE = 2'd0,
        K_READ  = 2'd1,
        K_POLL  = 2'd2
    } kind_e;

    typedef struct packed {
        kind_e       kind;
        logic [31:0] addr;
        logic [7:0]  data;
    } item_t;

    localparam logic [31:0] UNLOCK_ADDR_A = 32'h0000_0555;
    localparam logic [31:0] UNLOCK_ADDR_B = 32'h0000_02AA;
    localparam logic [7:0]  UNLOCK_BYTE_A = 8'hAA;
    localparam logic [7:0]  UNLOCK_BYTE_B = 8'h55;
    localparam logic [7:0]  CMD_PROGRAM   = 8'hA0;
    localparam logic [7:0]  CMD_ERASE_ARM = 8'h80;
    localparam logic [7:0]  CMD_ERASE_ALL = 8'h10;
    localparam logic [7:0]  CMD_IDENT     = 8'h90;
    localparam logic [7:0]  CMD_RESET     = 8'hF0;
    localparam logic [3:0]  RESET_LEN     = 4'd3;

    function automatic item_t mk_item(kind_e k, logic [31:0] a, logic [7:0] d);
        item_t it;
        it.kind = k;
        it.addr = a;
        it.data = d;
        return it;
    endfunction

    // Three-write group: two unlock writes then one command byte.
    function automatic item_t unlocked_cmd(logic [3:0] pos, logic [7:0] cmd);
        item_t it;
        case (pos)
            4'd0:    it = mk_item(K_WRITE, UNLOCK_ADDR_A, UNLOCK_BYTE_A);
            4'd1:    it = mk_item(K_WRITE, UNLOCK_ADDR_B, UNLOCK_BYTE_B);
            default: it = mk_item(K_WRITE, UNLOCK_ADDR_A, cmd);
        endcase
        return it;
    endfunction

    function automatic item_t script_item(logic [1:0] op, logic [3:0] idx,
                                          logic [31:0] tgt, logic [7:0] wd,
                                          logic in_rst);
        item_t it;
        if (in_rst) begin
            it = unlocked_cmd(idx, CMD_RESET);
        end else begin
            case (op)
                2'd0: begin
                    if (idx < 4'd3)       it = unlocked_cmd(idx, CMD_PROGRAM);
                    else if (idx == 4'd3) it = mk_item(K_WRITE, tgt, wd);
                    else                  it = mk_item(K_POLL, tgt, 8'h00);
                end
                2'd1: begin
                    if (idx < 4'd3)      it = unlocked_cmd(idx, CMD_ERASE_ARM);
                    else if (idx < 4'd6) it = unlocked_cmd(4'(idx - 4'd3), CMD_ERASE_ALL);
                    else                 it = mk_item(K_POLL, tgt, 8'h00);
                end
                default: begin
                    if (idx < 4'd3)       it = unlocked_cmd(idx, CMD_IDENT);
                    else if (idx == 4'd3) it = mk_item(K_READ, 32'h0, 8'h00);
                    else if (idx == 4'd4) it = mk_item(K_READ, 32'h1, 8'h00);
                    else                  it = unlocked_cmd(4'(idx - 4'd5), CMD_RESET);
                end
            endcase
        end
        return it;
    endfunction

    function automatic logic [3:0] script_len(logic [1:0] op);
        case (op)
            2'd0:    return 4'd5;
            2'd1:    return 4'd7;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/fseq_bus_engine.sv
module fseq_bus_engine #(
    parameter int AW      = 16,
    parameter int T_SETUP = 2,
    parameter int T_PULSE = 3,
    parameter int T_HOLD  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_wr,
    input  logic [AW-1:0] start_addr,
    input  logic [7:0]    start_data,
    input  logic [7:0]    dq_i,
    output logic          cyc_done_o,
    output logic [7:0]    rdata_o,
    output logic          ce_n_o,
    output logic          we_n_o,
    output logic          oe_n_o,
    output logic [AW-1:0] addr_o,
    output logic [7:0]    dq_o,
    output logic          dq_oe_o
);

    localparam int TMAX = (T_SETUP > T_PULSE) ? ((T_SETUP > T_HOLD) ? T_SETUP : T_HOLD)
                                              : ((T_PULSE > T_HOLD) ? T_PULSE : T_HOLD);
    localparam int CW = $clog2(TMAX) + 1;

    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD} phase_e;

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
        logic          wr;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic [7:0]    rdata;
    } eng_t;

    eng_t eng_d, eng_q;

    assign cyc_done_o = (eng_q.phase == PH_HOLD) && (eng_q.cnt == CW'(T_HOLD - 1));

    always_comb begin
        eng_d = eng_q;
        case (eng_q.phase)
            PH_SETUP: begin
                if (eng_q.cnt == CW'(T_SETUP - 1)) begin
                    eng_d.phase = PH_PULSE;
                    eng_d.cnt   = '0;
                end else begin
                    eng_d.cnt = eng_q.cnt + 1'b1;
                end
            end
            PH_PULSE: begin
                if (eng_q.cnt == CW'(T_PULSE - 1)) begin
                    eng_d.phase = PH_HOLD;
                    eng_d.cnt   = '0;
                    if (!eng_q.wr) eng_d.rdata = dq_i;
                end else begin
                    eng_d.cnt = eng_q.cnt + 1'b1;
                end
            end
            PH_HOLD: begin
                if (cyc_done_o) begin
                    eng_d.phase = PH_IDLE;
                    eng_d.cnt   = '0;
                end else begin
                    eng_d.cnt = eng_q.cnt + 1'b1;
                end
            end
            default: ;
        endcase
        if (start) begin
            eng_d.phase = PH_SETUP;
            eng_d.cnt   = '0;
            eng_d.wr    = start_wr;
            eng_d.addr  = start_addr;
            eng_d.data  = start_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign rdata_o = eng_q.rdata;
    assign ce_n_o  = (eng_q.phase == PH_IDLE);
    assign we_n_o  = !((eng_q.phase == PH_PULSE) && eng_q.wr);
    assign oe_n_o  = !((eng_q.phase == PH_PULSE) && !eng_q.wr);
    assign addr_o  = eng_q.addr;
    assign dq_o    = eng_q.data;
    assign dq_oe_o = (eng_q.phase != PH_IDLE) && eng_q.wr;

    AST_START_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (ce_n_o || cyc_done_o)); // R4

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n_o && $past(!ce_n_o) && !$past(cyc_done_o)) |-> ($stable(addr_o) && $stable(dq_o))); // R4

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n_o && !oe_n_o)); // R4

endmodule

// File: rtl/fseq_result_eval.sv
module fseq_result_eval (
    input  logic       is_erase,
    input  logic [7:0] rdata,
    input  logic [7:0] wdata,
    input  logic [7:0] id_lo,
    input  logic [7:0] id_hi,
    output logic       poll_ok,
    output logic       parity_err
);

    always_comb begin
        if (is_erase) poll_ok = rdata[7];
        else          poll_ok = (rdata[7] == wdata[7]);
        parity_err = !(^id_lo) || !(^id_hi);
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fseq_pkg::*;
#(
    parameter int AW        = 16,
    parameter int T_SETUP   = 2,
    parameter int T_PULSE   = 3,
    parameter int T_HOLD    = 2,
    parameter int MAX_POLLS = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    output logic          done,
    output logic [15:0]   rsp_data,
    output logic          err_timeout,
    output logic          err_parity,
    output logic          flash_ce_n,
    output logic          flash_we_n,
    output logic          flash_oe_n,
    output logic [AW-1:0] flash_addr,
    output logic [7:0]    flash_dq_o,
    output logic          flash_dq_oe,
    input  logic [7:0]    flash_dq_i
);

    localparam int PW = $clog2(MAX_POLLS + 1);

    typedef enum logic [1:0] {S_IDLE, S_RUN, S_RESP} state_e;

    typedef struct packed {
        state_e        state;
        logic [1:0]    op;
        logic [31:0]   tgt;
        logic [7:0]    wd;
        logic [3:0]    idx;
        logic          in_rst;
        logic [PW-1:0] polls;
        logic [7:0]    id_lo;
        logic [7:0]    id_hi;
        logic [7:0]    last;
        logic          tmo;
    } seq_t;

    seq_t  seq_d, seq_q;
    item_t cur_item, eng_item;
    logic  eng_start, eng_done, poll_ok, parity_err;
    logic  [7:0] eng_rdata;
    logic  [3:0] nxt_idx, seq_len;

    fseq_result_eval i_eval (
        .is_erase   (seq_q.op == 2'd1),
        .rdata      (eng_rdata),
        .wdata      (seq_q.wd),
        .id_lo      (seq_q.id_lo),
        .id_hi      (seq_q.id_hi),
        .poll_ok    (poll_ok),
        .parity_err (parity_err)
    );

    fseq_bus_engine #(
        .AW(AW), .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD)
    ) i_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (eng_start),
        .start_wr   (eng_item.kind == K_WRITE),
        .start_addr (eng_item.addr[AW-1:0]),
        .start_data (eng_item.data),
        .dq_i       (flash_dq_i),
        .cyc_done_o (eng_done),
        .rdata_o    (eng_rdata),
        .ce_n_o     (flash_ce_n),
        .we_n_o     (flash_we_n),
        .oe_n_o     (flash_oe_n),
        .addr_o     (flash_addr),
        .dq_o       (flash_dq_o),
        .dq_oe_o    (flash_dq_oe)
    );

    always_comb begin
        seq_d     = seq_q;
        eng_start = 1'b0;
        eng_item  = '0;
        cur_item  = script_item(seq_q.op, seq_q.idx, seq_q.tgt, seq_q.wd, seq_q.in_rst);
        nxt_idx   = seq_q.idx + 4'd1;
        seq_len   = seq_q.in_rst ? RESET_LEN : script_len(seq_q.op);
        case (seq_q.state)
            S_IDLE: begin
                if (req_valid) begin
                    seq_d.state  = S_RUN;
                    seq_d.op     = req_op;
                    seq_d.tgt    = 32'(req_addr);
                    seq_d.wd     = req_data;
                    seq_d.idx    = '0;
                    seq_d.in_rst = 1'b0;
                    seq_d.polls  = '0;
                    seq_d.id_lo  = '0;
                    seq_d.id_hi  = '0;
                    seq_d.last   = '0;
                    seq_d.tmo    = 1'b0;
                    eng_start    = 1'b1;
                    eng_item     = script_item(req_op, 4'd0, 32'(req_addr), req_data, 1'b0);
                end
            end
            S_RUN: begin
                if (eng_done) begin
                    if (cur_item.kind == K_POLL) begin
                        seq_d.last = eng_rdata;
                        if (poll_ok) begin
                            seq_d.state = S_RESP;
                        end else if (seq_q.polls == PW'(MAX_POLLS - 1)) begin
                            seq_d.in_rst = 1'b1;
                            seq_d.idx    = '0;
                            seq_d.tmo    = 1'b1;
                            eng_start    = 1'b1;
                            eng_item     = script_item(seq_q.op, 4'd0, seq_q.tgt, seq_q.wd, 1'b1);
                        end else begin
                            seq_d.polls = seq_q.polls + 1'b1;
                            eng_start   = 1'b1;
                            eng_item    = cur_item;
                        end
                    end else begin
                        if (cur_item.kind == K_READ) begin
                            if (seq_q.idx[0]) seq_d.id_lo = eng_rdata;
                            else              seq_d.id_hi = eng_rdata;
                        end
                        if (nxt_idx == seq_len) begin
                            seq_d.state = S_RESP;
                        end else begin
                            seq_d.idx = nxt_idx;
                            eng_start = 1'b1;
                            eng_item  = script_item(seq_q.op, nxt_idx, seq_q.tgt, seq_q.wd, seq_q.in_rst);
                        end
                    end
                end
            end
            S_RESP:  seq_d.state = S_IDLE;
            default: seq_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign req_ready   = (seq_q.state == S_IDLE);
    assign done        = (seq_q.state == S_RESP);
    assign rsp_data    = !done ? 16'h0000
                       : (seq_q.op[1] ? {seq_q.id_hi, seq_q.id_lo} : {8'h00, seq_q.last});
    assign err_timeout = done && seq_q.tmo;
    assign err_parity  = done && seq_q.op[1] && parity_err;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (flash_ce_n && flash_we_n && flash_oe_n && !flash_dq_oe)); // R1

    AST_READ_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_oe_n |-> !flash_dq_oe); // R5

    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.polls < PW'(MAX_POLLS)); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready)); // R11

    AST_FLAGS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!err_timeout && !err_parity && rsp_data == 16'h0000)); // R11

endmodule

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;

    localparam int AW   = 16;
    localparam int TS   = 2;
    localparam int TP   = 3;
    localparam int TH   = 2;
    localparam int MAXP = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic          done;
    logic [15:0]   rsp_data;
    logic          err_timeout, err_parity;
    logic          flash_ce_n, flash_we_n, flash_oe_n, flash_dq_oe;
    logic [AW-1:0] flash_addr;
    logic [7:0]    flash_dq_o;
    logic [7:0]    flash_dq_i;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    flash_cmd_seq #(
        .AW(AW), .T_SETUP(TS), .T_PULSE(TP), .T_HOLD(TH), .MAX_POLLS(MAXP)
    ) i_flash_cmd_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data),
        .done(done), .rsp_data(rsp_data),
        .err_timeout(err_timeout), .err_parity(err_parity),
        .flash_ce_n(flash_ce_n), .flash_we_n(flash_we_n), .flash_oe_n(flash_oe_n),
        .flash_addr(flash_addr), .flash_dq_o(flash_dq_o), .flash_dq_oe(flash_dq_oe),
        .flash_dq_i(flash_dq_i)
    );

    // Behavioural device: polls see busy_byte for busy_n reads, then done_byte.
    bit       id_mode = 0;
    int       rd_cnt = 0;
    int       busy_n = 0;
    logic [7:0] busy_byte = 8'h00, done_byte = 8'h00, mfr_byte = 8'h00, dev_byte = 8'h00;
    logic     oe_prev = 1'b1;

    always_comb begin
        if (id_mode) flash_dq_i = (flash_addr == '0) ? mfr_byte : dev_byte;
        else         flash_dq_i = (rd_cnt < busy_n) ? busy_byte : done_byte;
    end

    always @(negedge clk) begin
        if (!oe_prev && flash_oe_n) rd_cnt = rd_cnt + 1;
        oe_prev = flash_oe_n;
    end

    typedef struct {
        bit ce, we, oe, dqoe, dn, rdy, tmo, par;
        int addr;
        int data;
        int rsp;
        string tag;
    } exp_t;

    exp_t expq[$];
    bit   mon_on = 0;

    task automatic push(bit ce, bit we, bit oe, bit dqoe, bit dn, bit rdy,
                        int a, int d, int rsp, bit tmo, bit par, string tag);
        exp_t e;
        e.ce = ce; e.we = we; e.oe = oe; e.dqoe = dqoe; e.dn = dn; e.rdy = rdy;
        e.addr = a; e.data = d; e.rsp = rsp; e.tmo = tmo; e.par = par; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic bus_cyc(bit wr, int a, int d, string tag);
        for (int i = 0; i < TS; i++) push(0, 1, 1, wr, 0, 0, a, d, 0, 0, 0, tag);
        for (int i = 0; i < TP; i++) push(0, !wr, wr, wr, 0, 0, a, d, 0, 0, 0, tag);
        for (int i = 0; i < TH; i++) push(0, 1, 1, wr, 0, 0, a, d, 0, 0, 0, tag);
    endtask

    task automatic unlock_cmd(int cmd, string tag);
        bus_cyc(1, 'h555, 'hAA, tag);
        bus_cyc(1, 'h2AA, 'h55, tag);
        bus_cyc(1, 'h555, cmd, tag);
    endtask

    // Cycle-by-cycle comparison, sampled 5 ns after each rising edge.
    always @(posedge clk) begin
        #5;
        if (mon_on) begin
            exp_t e;
            bit ok;
            if (expq.size() > 0) begin
                e = expq.pop_front();
            end else begin
                e.ce = 1; e.we = 1; e.oe = 1; e.dqoe = 0; e.dn = 0; e.rdy = 1;
                e.tmo = 0; e.par = 0; e.addr = 0; e.data = 0; e.rsp = 0; e.tag = "R1 idle";
            end
            ok = ({flash_ce_n, flash_we_n, flash_oe_n, flash_dq_oe, done, req_ready, err_timeout, err_parity}
                  == {e.ce, e.we, e.oe, e.dqoe, e.dn, e.rdy, e.tmo, e.par})
                 && (e.ce || flash_addr == AW'(e.addr))
                 && (!e.dqoe || flash_dq_o == 8'(e.data))
                 && (rsp_data == 16'(e.rsp));
            checks++;
            if (!ok) begin
                failures++;
                $display("FAIL %s: got ce%b we%b oe%b oe_dq%b done%b rdy%b tmo%b par%b addr=%h dq=%h rsp=%h exp ce%b we%b oe%b oe_dq%b done%b rdy%b tmo%b par%b addr=%h dq=%h rsp=%h",
                         e.tag, flash_ce_n, flash_we_n, flash_oe_n, flash_dq_oe, done, req_ready,
                         err_timeout, err_parity, flash_addr, flash_dq_o, rsp_data,
                         e.ce, e.we, e.oe, e.dqoe, e.dn, e.rdy, e.tmo, e.par,
                         AW'(e.addr), 8'(e.data), 16'(e.rsp));
            end
        end
    end

    // Polling phase shared by program and erase.
    task automatic poll_tail(int a, int bn, logic [7:0] bb, logic [7:0] db, string tag,
                             output int rsp, output bit tmo);
        int n;
        n   = (bn < MAXP) ? bn + 1 : MAXP;
        tmo = (bn >= MAXP);
        for (int k = 0; k < n; k++) bus_cyc(0, a, 0, tag);
        rsp = ((n - 1) < bn) ? int'(bb) : int'(db);
        if (tmo) unlock_cmd('hF0, "R8 reset writes");
    endtask

    task automatic run_op(logic [1:0] op, int a, logic [7:0] d,
                          int bn, logic [7:0] bb, logic [7:0] db,
                          logic [7:0] mfr, logic [7:0] dev, bit poke);
        int rsp;
        bit tmo;
        bit par;
        while (expq.size() != 0) @(negedge clk);
        @(negedge clk);
        id_mode = op[1]; busy_n = bn; busy_byte = bb; done_byte = db;
        mfr_byte = mfr; dev_byte = dev; rd_cnt = 0;
        rsp = 0; tmo = 0; par = 0;
        if (op == 2'd0) begin
            unlock_cmd('hA0, "R2 R4 program prefix");
            bus_cyc(1, a, d, "R2 R13 program data write");
            poll_tail(a, bn, bb, db, "R6 R5 program poll", rsp, tmo);
        end else if (op == 2'd1) begin
            unlock_cmd('h80, "R3 R4 erase arm");
            unlock_cmd('h10, "R3 R4 erase go");
            poll_tail(a, bn, bb, db, "R7 R5 erase poll", rsp, tmo);
        end else begin
            unlock_cmd('h90, "R9 ident entry");
            bus_cyc(0, 0, 0, "R9 R5 ident read 0");
            bus_cyc(0, 1, 0, "R9 R5 ident read 1");
            unlock_cmd('hF0, "R9 ident exit");
            rsp = {dev, mfr};
            par = !(^mfr) || !(^dev);
        end
        push(1, 1, 1, 0, 1, 0, 0, 0, rsp, tmo, par, par ? "R10 R11 done" : (tmo ? "R8 R11 done" : "R11 done"));
        req_valid = 1'b1; req_op = op; req_addr = AW'(a); req_data = d;
        @(negedge clk);
        if (poke) begin
            // R1: a second request held valid mid-run must be ignored
            req_op = 2'd1; req_addr = 16'hBEEF; req_data = 8'h11;
            repeat (10) @(negedge clk);
        end
        req_valid = 1'b0;
        while (expq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_reset(string when);
        checks++;
        if (!({flash_ce_n, flash_we_n, flash_oe_n, flash_dq_oe, done, req_ready} == 6'b111001)) begin
            failures++;
            $display("FAIL R12 %s: got ce%b we%b oe%b oe_dq%b done%b rdy%b exp ce1 we1 oe1 oe_dq0 done0 rdy1",
                     when, flash_ce_n, flash_we_n, flash_oe_n, flash_dq_oe, done, req_ready);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish, got hung exp completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset("during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_reset("after reset");
        mon_on = 1;
        repeat (3) @(negedge clk);
        // R2 R6: program with three busy polls
        run_op(2'd0, 'h1234, 8'h5A, 3, 8'hDA, 8'h5A, 8'h00, 8'h00, 0);
        // R13: top address, finishes on first poll
        run_op(2'd0, 'hFFFF, 8'hC3, 0, 8'h00, 8'hC3, 8'h00, 8'h00, 0);
        // R13: address zero, finishes on last allowed poll
        run_op(2'd0, 'h0000, 8'h80, MAXP - 1, 8'h00, 8'h80, 8'h00, 8'h00, 0);
        // R8 R1: program never finishes, with a request held during the run
        run_op(2'd0, 'h0042, 8'h80, 50, 8'h13, 8'h80, 8'h00, 8'h00, 1);
        // R3 R7: chip erase
        run_op(2'd1, 'h0400, 8'h00, 4, 8'h00, 8'hFF, 8'h00, 8'h00, 0);
        // R8: erase timeout
        run_op(2'd1, 'h0007, 8'h00, 99, 8'h7F, 8'hFF, 8'h00, 8'h00, 0);
        // R9: identify with good parity
        run_op(2'd2, 0, 8'h00, 0, 8'h00, 8'h00, 8'h01, 8'hA4, 0);
        // R10: identify with an even-parity manufacturer byte
        run_op(2'd2, 0, 8'h00, 0, 8'h00, 8'h00, 8'h03, 8'hA4, 0);
        // R9 R10: op code 3, device byte even parity
        run_op(2'd3, 0, 8'h00, 0, 8'h00, 8'h00, 8'h01, 8'h27, 0);
        repeat (5) @(negedge clk);
        mon_on = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule